// File: doc/BRIEF.md
# H-Bridge Control and Fault Sequencer

This block is the digital control core of one full H-bridge. Two control inputs pass through a two-flop synchronizer and are then decoded into four gate enables: a high-side and a low-side enable for each of the two half-bridges (legs). A mode pin selects how the two inputs are read. In independent-input style each input steers one leg. In phase/enable style one input gives the direction and the other gates the drive. Analog sensing, gate drivers and the power switches sit outside the block.

The block also handles the active-low sleep pin and a wake-up delay. It responds to three digitised fault flags, and each uses its own recovery policy. An overcurrent flag is deglitched, and a trip is followed by a timed automatic retry. An undervoltage flag holds the bridge off for as long as it is asserted, and so does an overtemperature flag. The deglitch, retry and wake durations are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. Every change of a leg's drive from one rail to the other passes through a dead time in which both of its switches are off. A two-bit fault code reports the fault that is active.

Top module: `hbridge_ctrl`

## Requirements
- R1: With `mode_pe`=0 the legs follow (`ctl_a`,`ctl_b`): (0,0) both legs off; (1,0) leg 1 high, leg 2 low; (0,1) leg 1 low, leg 2 high; (1,1) both legs low. "High" means `outN_hi_en`=1 and `outN_lo_en`=0, "low" the reverse, "off" both 0.
- R2: With `mode_pe`=1, `ctl_b`=0 puts both legs low whatever `ctl_a` is. With `ctl_b`=1, `ctl_a`=0 gives leg 1 high and leg 2 low, and `ctl_a`=1 gives leg 1 low and leg 2 high.
- R3: Reset leaves the block asleep with all four enables at 0. While `sleep_n` is 0, all four enables read 0 from the fourth clock edge after it falls, whatever the control inputs are.
- R4: After `sleep_n` rises, all enables stay 0 through clock edge WAKE+3, where WAKE is the wake time in cycles. The decoded drive appears at edge WAKE+4.
- R5: `oc_flag` must be high for DEG consecutive clock cycles before an overcurrent trip occurs. A pulse of DEG-1 cycles changes neither the enables nor `fault_code`.
- R6: An overcurrent trip turns every enable off for RETRY cycles. The drive then resumes by itself, without any change to the inputs.
- R7: While `uv_flag` is high all enables are 0. The drive resumes as soon as the flag clears.
- R8: While `ot_flag` is high all enables are 0. The drive resumes as soon as the flag clears.
- R9: The high and low enables of one leg are never both 1. A change of a leg from high to low, or from low to high, passes through exactly DEAD cycles in which both enables of that leg are 0.
- R10: `fault_code` reads 0 for none, 1 for overcurrent trip, 2 for undervoltage and 3 for overtemperature. When several faults are active, the priority order is undervoltage, then overtemperature, then overcurrent.
- R11: Entering sleep cancels a pending overcurrent retry. After the next wake the drive returns without waiting for the retry time, and `fault_code` reads 0 during sleep.
- R12: A control input change reaches the enables at the third clock edge after it, when no dead time is pending (two synchronizer flops plus the leg register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep request |
| mode_pe | input | 1 | Decode style: 0 independent inputs, 1 phase/enable |
| ctl_a | input | 1 | Control input A (leg-1 input, or phase) |
| ctl_b | input | 1 | Control input B (leg-2 input, or enable) |
| oc_flag | input | 1 | Digitised overcurrent flag |
| uv_flag | input | 1 | Undervoltage flag |
| ot_flag | input | 1 | Overtemperature flag |
| out1_hi_en | output | 1 | Leg 1 high-side switch enable |
| out1_lo_en | output | 1 | Leg 1 low-side switch enable |
| out2_hi_en | output | 1 | Leg 2 high-side switch enable |
| out2_lo_en | output | 1 | Leg 2 low-side switch enable |
| fault_code | output | 2 | Active fault: 0 none, 1 overcurrent, 2 undervoltage, 3 overtemperature |

## Verification
The assertions assume that reset is held for several cycles. They also count a sleep request or fault as settled only after it has been seen on consecutive edges, so the synchronizer and state latency have passed before the switches are required to be off. The stimulus changes every input on the falling clock edge, never at the sampling edge. Fault flags are held as whole-cycle levels, and the random section waits longer than the dead time plus the pipeline depth before each comparison, so that every check sees a settled drive.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;

    // Drive requested for, or applied to, one half-bridge leg
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_cmd_e;

    // Encoded fault report; values are visible at the block's port
    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_OVERCUR  = 2'd1,
        FLT_UNDERV   = 2'd2,
        FLT_OVERTEMP = 2'd3
    } fault_code_e;

    // Bridge sequencing states
    typedef enum logic [1:0] {
        ST_ASLEEP = 2'd0,
        ST_WAKING = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HALTED = 2'd3
    } bridge_state_e;

    // Duration in ns to whole clock cycles, never below one
    function automatic int cyc_of(input longint unsigned hz, input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns) / 64'd1000000000;
        return (c == 64'd0) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;
endmodule

// File: rtl/hb_decode.sv
`timescale 1ns/1ps
module hb_decode
    import hb_pkg::*;
(
    input  logic     phase_mode,
    input  logic     in_a,
    input  logic     in_b,
    output leg_cmd_e leg1_cmd,
    output leg_cmd_e leg2_cmd
);
    always_comb begin
        leg1_cmd = LEG_OFF;
        leg2_cmd = LEG_OFF;
        if (phase_mode) begin
            // in_a selects direction, in_b gates the drive
            unique case ({in_b, in_a})
                2'b00, 2'b01: begin leg1_cmd = LEG_LOW;  leg2_cmd = LEG_LOW;  end
                2'b10:        begin leg1_cmd = LEG_HIGH; leg2_cmd = LEG_LOW;  end
                2'b11:        begin leg1_cmd = LEG_LOW;  leg2_cmd = LEG_HIGH; end
            endcase
        end else begin
            // each input steers its own leg
            unique case ({in_a, in_b})
                2'b00: begin leg1_cmd = LEG_OFF;  leg2_cmd = LEG_OFF;  end
                2'b01: begin leg1_cmd = LEG_LOW;  leg2_cmd = LEG_HIGH; end
                2'b10: begin leg1_cmd = LEG_HIGH; leg2_cmd = LEG_LOW;  end
                2'b11: begin leg1_cmd = LEG_LOW;  leg2_cmd = LEG_LOW;  end
            endcase
        end
    end
endmodule

// File: rtl/hb_fault.sv
`timescale 1ns/1ps
module hb_fault
    import hb_pkg::*;
#(
    parameter int DEG_CYC   = 250,
    parameter int RETRY_CYC = 250000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        oc_s,
    input  logic        uv_s,
    input  logic        ot_s,
    output logic        halt,
    output fault_code_e code
);
    localparam int DGW = $clog2(DEG_CYC + 1);
    localparam int RTW = $clog2(RETRY_CYC + 1);

    logic           trip_q;
    logic [DGW-1:0] deg_q;
    logic [RTW-1:0] retry_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q  <= 1'b0;
            deg_q   <= '0;
            retry_q <= '0;
        end else if (clr) begin
            trip_q  <= 1'b0;
            deg_q   <= '0;
            retry_q <= '0;
        end else if (trip_q) begin
            if (retry_q == RTW'(RETRY_CYC - 1)) begin
                trip_q  <= 1'b0;
                retry_q <= '0;
            end else begin
                retry_q <= retry_q + 1'b1;
            end
        end else if (oc_s) begin
            if (deg_q == DGW'(DEG_CYC - 1)) begin
                trip_q <= 1'b1;
                deg_q  <= '0;
            end else begin
                deg_q <= deg_q + 1'b1;
            end
        end else begin
            deg_q <= '0;
        end
    end

    always_comb begin
        if (uv_s)        code = FLT_UNDERV;
        else if (ot_s)   code = FLT_OVERTEMP;
        else if (trip_q) code = FLT_OVERCUR;
        else             code = FLT_NONE;
    end

    assign halt = uv_s | ot_s | trip_q;
endmodule

// File: rtl/hb_leg.sv
`timescale 1ns/1ps
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  leg_cmd_e want,
    output logic     hi_en,
    output logic     lo_en
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    leg_cmd_e      cur_q;
    logic [DW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= LEG_OFF;
            gap_q <= '0;
        end else if (cur_q != LEG_OFF && (!en || want != cur_q)) begin
            // leaving a driven rail always opens a dead gap first
            cur_q <= LEG_OFF;
            gap_q <= DW'(DEAD_CYC - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end else if (en) begin
            cur_q <= want;
        end
    end

    assign hi_en = (cur_q == LEG_HIGH);
    assign lo_en = (cur_q == LEG_LOW);
endmodule

// File: rtl/hbridge_ctrl.sv
`timescale 1ns/1ps
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 250000000,
    parameter longint unsigned DEGLITCH_NS = 1000,
    parameter longint unsigned RETRY_NS    = 1000000,
    parameter longint unsigned WAKE_NS     = 30000,
    parameter int              DEAD_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_n,
    input  logic       mode_pe,
    input  logic       ctl_a,
    input  logic       ctl_b,
    input  logic       oc_flag,
    input  logic       uv_flag,
    input  logic       ot_flag,
    output logic       out1_hi_en,
    output logic       out1_lo_en,
    output logic       out2_hi_en,
    output logic       out2_lo_en,
    output logic [1:0] fault_code
);
    localparam int DEG_CYC   = cyc_of(CLK_HZ, DEGLITCH_NS);
    localparam int RETRY_CYC = cyc_of(CLK_HZ, RETRY_NS);
    localparam int WAKE_CYC  = cyc_of(CLK_HZ, WAKE_NS);
    localparam int WW        = $clog2(WAKE_CYC + 1);
    localparam int NLEG      = 2;
    localparam int NSYNC     = 7;

    // ---------------- input synchronizer ----------------
    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn_in;
    logic awake_s, pe_s, a_s, b_s, oc_s, uv_s, ot_s;

    assign raw_in = {sleep_n, mode_pe, ctl_a, ctl_b, oc_flag, uv_flag, ot_flag};

    hb_sync #(.WIDTH(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    assign {awake_s, pe_s, a_s, b_s, oc_s, uv_s, ot_s} = syn_in;

    // ---------------- decode ----------------
    leg_cmd_e want_cmd [NLEG];

    hb_decode u_decode (
        .phase_mode (pe_s),
        .in_a       (a_s),
        .in_b       (b_s),
        .leg1_cmd   (want_cmd[0]),
        .leg2_cmd   (want_cmd[1])
    );

    // ---------------- fault handling ----------------
    logic        halt;
    fault_code_e code_e;

    hb_fault #(
        .DEG_CYC   (DEG_CYC),
        .RETRY_CYC (RETRY_CYC)
    ) u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!awake_s),
        .oc_s  (oc_s),
        .uv_s  (uv_s),
        .ot_s  (ot_s),
        .halt  (halt),
        .code  (code_e)
    );

    assign fault_code = code_e;

    // ---------------- sequencing state machine ----------------
    bridge_state_e state_q, state_d;
    logic [WW-1:0] wake_q, wake_d;
    logic          bridge_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ASLEEP;
            wake_q  <= '0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    always_comb begin
        state_d = state_q;
        wake_d  = wake_q;
        unique case (state_q)
            ST_ASLEEP: begin
                if (awake_s) begin
                    state_d = ST_WAKING;
                    wake_d  = '0;
                end
            end
            ST_WAKING: begin
                if (!awake_s)                            state_d = ST_ASLEEP;
                else if (wake_q == WW'(WAKE_CYC - 1))    state_d = halt ? ST_HALTED : ST_ACTIVE;
                else                                     wake_d  = wake_q + 1'b1;
            end
            ST_ACTIVE: begin
                if (!awake_s)  state_d = ST_ASLEEP;
                else if (halt) state_d = ST_HALTED;
            end
            ST_HALTED: begin
                if (!awake_s)   state_d = ST_ASLEEP;
                else if (!halt) state_d = ST_ACTIVE;
            end
        endcase
    end

    always_comb begin
        bridge_en = 1'b0;
        unique case (state_q)
            ST_ASLEEP, ST_WAKING, ST_HALTED: bridge_en = 1'b0;
            ST_ACTIVE:                       bridge_en = 1'b1;
        endcase
    end

    // ---------------- legs with dead time ----------------
    logic [NLEG-1:0] hi_v, lo_v;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bridge_en),
            .want  (want_cmd[g]),
            .hi_en (hi_v[g]),
            .lo_en (lo_v[g])
        );
    end

    assign out1_hi_en = hi_v[0];
    assign out1_lo_en = lo_v[0];
    assign out2_hi_en = hi_v[1];
    assign out2_lo_en = lo_v[1];
endmodule

// File: rtl/hb_ctrl_chk.sv
`timescale 1ns/1ps
module hb_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_n,
    input logic       out1_hi_en,
    input logic       out1_lo_en,
    input logic       out2_hi_en,
    input logic       out2_lo_en,
    input logic [1:0] fault_code
);
    logic all_off;
    assign all_off = !out1_hi_en && !out1_lo_en && !out2_hi_en && !out2_lo_en;

    AST_LEG1_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out1_hi_en && out1_lo_en)); // R9
    AST_LEG2_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out2_hi_en && out2_lo_en)); // R9
    AST_LEG1_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !((out1_lo_en && $past(out1_hi_en)) || (out1_hi_en && $past(out1_lo_en)))); // R9
    AST_LEG2_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !((out2_lo_en && $past(out2_hi_en)) || (out2_hi_en && $past(out2_lo_en)))); // R9
    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sleep_n, 1) && !$past(sleep_n, 2) && !$past(sleep_n, 3) && !$past(sleep_n, 4))
        |-> all_off); // R3
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code != 2'd0) && ($past(fault_code) != 2'd0) && ($past(fault_code, 2) != 2'd0))
        |-> all_off); // R7
endmodule

bind hbridge_ctrl hb_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_n    (sleep_n),
    .out1_hi_en (out1_hi_en),
    .out1_lo_en (out1_lo_en),
    .out2_hi_en (out2_hi_en),
    .out2_lo_en (out2_lo_en),
    .fault_code (fault_code)
);

// File: tb/hbridge_ctrl_tb.sv
`timescale 1ns/1ps
module hbridge_ctrl_tb;
    localparam longint unsigned T_HZ = 10000000;
    localparam int DEAD_T  = 3;
    localparam int DEG_T   = 10;     // 1 us at the scaled rate
    localparam int RETRY_T = 10000;  // 1 ms
    localparam int WAKE_T  = 300;    // 30 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_n = 1'b0, mode_pe = 1'b0, ctl_a = 1'b0, ctl_b = 1'b0;
    logic oc_flag = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
    logic out1_hi_en, out1_lo_en, out2_hi_en, out2_lo_en;
    logic [1:0] fault_code;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    hbridge_ctrl #(
        .CLK_HZ   (T_HZ),
        .DEAD_CYC (DEAD_T)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .mode_pe(mode_pe),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .oc_flag(oc_flag), .uv_flag(uv_flag),
        .ot_flag(ot_flag), .out1_hi_en(out1_hi_en), .out1_lo_en(out1_lo_en),
        .out2_hi_en(out2_hi_en), .out2_lo_en(out2_lo_en), .fault_code(fault_code)
    );

    localparam logic [3:0] OFF4 = 4'b0000;

    // {leg1 hi, leg1 lo, leg2 hi, leg2 lo}
    function automatic logic [3:0] exp_legs(input logic pe, input logic a, input logic b);
        if (pe) begin
            if (!b)     return 4'b0101;
            else if (a) return 4'b0110;
            else        return 4'b1001;
        end
        case ({a, b})
            2'b00:   return 4'b0000;
            2'b01:   return 4'b0110;
            2'b10:   return 4'b1001;
            default: return 4'b0101;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_legs(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {out1_hi_en, out1_lo_en, out2_hi_en, out2_lo_en};
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s enables got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic chk_code(input string tag, input logic [1:0] exp);
        n_chk++;
        if (fault_code !== exp) begin
            n_err++;
            $display("FAIL %s fault_code got %0d exp %0d", tag, fault_code, exp);
        end
    endtask

    task automatic set_ctl(input logic pe, input logic a, input logic b);
        mode_pe = pe; ctl_a = a; ctl_b = b;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired got running exp finished");
        summary();
        $finish;
    end

    initial begin
        int gaps;
        void'($urandom(32'd20240611));
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk_legs("R3 reset", OFF4);
        chk_code("R10 reset", 2'd0);

        // R3: asleep with an active command
        set_ctl(1'b0, 1'b1, 1'b0);
        tick(10);
        chk_legs("R3 asleep ignores inputs", OFF4);

        // R4: wake delay
        sleep_n = 1'b1;
        tick(WAKE_T + 3);
        chk_legs("R4 still waking", OFF4);
        tick(1);
        chk_legs("R4 awake", 4'b1001);

        // R12: synchronizer latency from coast
        set_ctl(1'b0, 1'b0, 1'b0);
        tick(DEAD_T + 8);
        chk_legs("R1 coast", OFF4);
        ctl_a = 1'b1;
        tick(2);
        chk_legs("R12 before third edge", OFF4);
        tick(1);
        chk_legs("R12 at third edge", 4'b1001);

        // R1 and R2 directed
        for (int i = 0; i < 8; i++) begin
            set_ctl(i[2], i[1], i[0]);
            tick(DEAD_T + 8);
            chk_legs(i[2] ? "R2 directed" : "R1 directed", exp_legs(i[2], i[1], i[0]));
        end

        // R9: reversal dead time
        set_ctl(1'b0, 1'b1, 1'b0);
        tick(DEAD_T + 8);
        set_ctl(1'b0, 1'b0, 1'b1);
        gaps = 0;
        for (int i = 0; i < DEAD_T + 8; i++) begin
            tick(1);
            if (!out1_hi_en && !out1_lo_en) gaps++;
        end
        n_chk++;
        if (gaps != DEAD_T) begin
            n_err++;
            $display("FAIL R9 leg1 dead cycles got %0d exp %0d", gaps, DEAD_T);
        end
        chk_legs("R9 after reversal", 4'b0110);

        // R1/R2 random
        for (int i = 0; i < 40; i++) begin
            logic pe, a, b;
            pe = 1'($urandom); a = 1'($urandom); b = 1'($urandom);
            set_ctl(pe, a, b);
            tick(DEAD_T + 8);
            chk_legs(pe ? "R2 random" : "R1 random", exp_legs(pe, a, b));
        end

        // R5: short overcurrent pulse ignored
        set_ctl(1'b0, 1'b1, 1'b0);
        tick(DEAD_T + 8);
        oc_flag = 1'b1;
        tick(DEG_T - 1);
        oc_flag = 1'b0;
        tick(10);
        chk_legs("R5 glitch ignored", 4'b1001);
        chk_code("R5 glitch ignored", 2'd0);

        // R5/R6: trip and retry
        oc_flag = 1'b1;
        tick(DEG_T);
        oc_flag = 1'b0;
        tick(6);
        chk_legs("R5 trip", OFF4);
        chk_code("R10 overcurrent", 2'd1);
        tick(RETRY_T - 10);
        chk_legs("R6 still in retry", OFF4);
        tick(14);
        chk_legs("R6 resumed", 4'b1001);
        chk_code("R6 resumed", 2'd0);

        // R7 undervoltage
        uv_flag = 1'b1;
        tick(5);
        chk_legs("R7 held off", OFF4);
        chk_code("R7 code", 2'd2);
        uv_flag = 1'b0;
        tick(6);
        chk_legs("R7 resumed", 4'b1001);

        // R8 overtemperature
        ot_flag = 1'b1;
        tick(5);
        chk_legs("R8 held off", OFF4);
        chk_code("R8 code", 2'd3);
        ot_flag = 1'b0;
        tick(6);
        chk_legs("R8 resumed", 4'b1001);
        chk_code("R8 cleared", 2'd0);

        // R10 priority
        uv_flag = 1'b1; ot_flag = 1'b1;
        tick(4);
        chk_code("R10 uv over ot", 2'd2);
        uv_flag = 1'b0;
        tick(4);
        chk_code("R10 ot alone", 2'd3);
        oc_flag = 1'b1;
        tick(DEG_T);
        oc_flag = 1'b0;
        tick(6);
        chk_code("R10 ot over oc", 2'd3);
        ot_flag = 1'b0;
        tick(4);
        chk_code("R10 oc after ot clears", 2'd1);

        // R11: sleep cancels retry
        sleep_n = 1'b0;
        tick(4);
        chk_code("R11 sleep clears trip", 2'd0);
        chk_legs("R3 sleep from halted", OFF4);
        sleep_n = 1'b1;
        tick(WAKE_T + 8);
        chk_legs("R11 drive back before retry", 4'b1001);
        chk_code("R11 no fault after wake", 2'd0);

        // R3: sleep while driving
        sleep_n = 1'b0;
        tick(4);
        chk_legs("R3 sleep while driving", OFF4);

        summary();
        $finish;
    end
endmodule